// File: doc/BRIEF.md
# Burst Low-Address Sequencer

This block produces the two least significant address bits for a four-beat burst into a memory whose words are grouped in fours. At the start of a burst a full word address is captured. The upper address bits are then held at their captured value for the whole burst. The two low bits step through the four words of the aligned group, one word for each cycle in which the advance control is asserted. In cycles where advance is low, the address stays where it is, which lets a master insert wait states.

The visiting order is chosen at run time by an order-select input. Linear order counts upward from the start word and wraps inside the group. Interleaved order visits the words in the order given by the start word XOR the beat number. Strobe decoding and the memory array both sit outside this block. A decoded capture pulse and a decoded advance pulse arrive on their own inputs. The block keeps an internal beat counter, and the output is formed each cycle from the captured start word, that counter and the current order select.

Top module: `bsq_burst_seq`

## Requirements
- R1: While reset (`rst_n` low) is asserted, and in the first cycle after it, `burst_lo_o` and `addr_hi_o` read all zeros.
- R2: The cycle after a clock edge with `load_i` high, `burst_lo_o` equals the captured `addr_i[1:0]` (beat 0), whatever the order select.
- R3: `addr_hi_o` equals `addr_i[ADDR_W-1:2]` as captured at the last load, and it does not change at any edge without `load_i`.
- R4: At an edge with `load_i` and `adv_i` both low, the burst address holds (suspend).
- R5: With `order_i` = 1 (interleaved), `burst_lo_o` = start XOR beat, so that start 01 gives 01,00,11,10 and start 10 gives 10,11,00,01.
- R6: With `order_i` = 0 (linear), `burst_lo_o` = (start + beat) mod 4, wrapping from 11 to 00.
- R7: Each edge with `adv_i` high and `load_i` low moves the beat on by one. After the fourth beat it wraps to beat 0 and keeps cycling.
- R8: When `load_i` and `adv_i` are both high, the load wins: the new start is captured and the beat returns to 0.
- R9: `order_i` is applied combinationally, so changing it mid-burst immediately remaps the current beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Capture addr_i and restart the burst |
| adv_i | input | 1 | Step to the next beat |
| order_i | input | 1 | 1 selects interleaved order, 0 selects linear |
| addr_i | input | ADDR_W | External word address to capture |
| burst_lo_o | output | 2 | Current low two address bits |
| addr_hi_o | output | ADDR_W-2 | Captured upper address bits |

## Verification
Every start value from 00 to 11 is run in both orders for six advancing beats. The six beats are enough to cover the wrap at the fourth beat, and because XOR and addition disagree on starts 01 and 11, the two order formulas cannot be mistaken for each other. Runs of idle cycles check suspend. A load issued together with advance checks the priority rule. Changing `addr_i` without a load checks that the upper bits are held. Flipping `order_i` at beat 1 of a start-01 burst must move the output from 10 to 00, which shows the mapping is live.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
    localparam int BEAT_W = 2;
    typedef logic [BEAT_W-1:0] beat_t;
    typedef enum logic {
        ORD_LINEAR      = 1'b0,
        ORD_INTERLEAVED = 1'b1
    } order_e;
endpackage

// File: rtl/bsq_beat_ctr.sv
module bsq_beat_ctr
    import bsq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load_i,
    input  logic  adv_i,
    output beat_t beat_o
);
    typedef struct packed {
        beat_t beat;
    } ctr_s;

    ctr_s ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (load_i) begin
            ctr_d.beat = '0;
        end else if (adv_i) begin
            ctr_d.beat = beat_t'(ctr_q.beat + beat_t'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign beat_o = ctr_q.beat;

    // R8: load restarts at beat 0 even with advance
    p_load_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (beat_o == '0));

    // R7: advance steps by one, wrapping modulo four
    p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i) |=> (beat_o == beat_t'($past(beat_o) + beat_t'(1))));

    // R4: suspend holds the beat
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !load_i) |=> $stable(beat_o));
endmodule

// File: rtl/bsq_addr_map.sv
module bsq_addr_map
    import bsq_pkg::*;
(
    input  beat_t  start_i,
    input  beat_t  beat_i,
    input  order_e order_i,
    output beat_t  addr_o
);
    beat_t xor_addr;
    beat_t lin_addr;

    for (genvar g = 0; g < BEAT_W; g++) begin : g_xor_bit
        assign xor_addr[g] = start_i[g] ^ beat_i[g];
    end

    assign lin_addr = beat_t'(start_i + beat_i);

    always_comb begin
        addr_o = (order_i == ORD_INTERLEAVED) ? xor_addr : lin_addr;
    end
endmodule

// File: rtl/bsq_burst_seq.sv
module bsq_burst_seq
    import bsq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  logic                     adv_i,
    input  logic                     order_i,
    input  logic [ADDR_W-1:0]        addr_i,
    output logic [BEAT_W-1:0]        burst_lo_o,
    output logic [ADDR_W-BEAT_W-1:0] addr_hi_o
);
    localparam int HI_W = ADDR_W - BEAT_W;

    typedef struct packed {
        logic [HI_W-1:0] hi;
        beat_t           start;
    } cap_s;

    cap_s  cap_d, cap_q;
    beat_t beat;
    beat_t mapped;

    always_comb begin
        cap_d = cap_q;
        if (load_i) begin
            cap_d.hi    = addr_i[ADDR_W-1:BEAT_W];
            cap_d.start = addr_i[BEAT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    bsq_beat_ctr u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_i),
        .adv_i  (adv_i),
        .beat_o (beat)
    );

    bsq_addr_map u_map (
        .start_i (cap_q.start),
        .beat_i  (beat),
        .order_i (order_e'(order_i)),
        .addr_o  (mapped)
    );

    assign burst_lo_o = mapped;
    assign addr_hi_o  = cap_q.hi;

    // R2: the first beat after a load is the captured start
    p_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (burst_lo_o == $past(addr_i[BEAT_W-1:0])));

    // R3: upper bits follow a load and are otherwise frozen
    p_hi_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (addr_hi_o == $past(addr_i[ADDR_W-1:BEAT_W])));
    p_hi_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(addr_hi_o));

    // R4: with order fixed, suspend freezes the output
    p_suspend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_i && $stable(order_i)) |=> $stable(burst_lo_o));
endmodule

// File: tb/bsq_burst_seq_tb.sv
module bsq_burst_seq_tb;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 16;
    localparam int HI_W   = ADDR_W - 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              load_i;
    logic              adv_i;
    logic              order_i;
    logic [ADDR_W-1:0] addr_i;
    logic [1:0]        burst_lo_o;
    logic [HI_W-1:0]   addr_hi_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    bsq_burst_seq #(.ADDR_W(ADDR_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_i),
        .adv_i      (adv_i),
        .order_i    (order_i),
        .addr_i     (addr_i),
        .burst_lo_o (burst_lo_o),
        .addr_hi_o  (addr_hi_o)
    );

    function automatic logic [1:0] expect_lo(input logic ord, input logic [1:0] s, input int k);
        logic [1:0] b;
        b = 2'(k % 4);
        return ord ? (s ^ b) : 2'(s + b);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_load(input logic [ADDR_W-1:0] a, input logic with_adv);
        load_i = 1'b1;
        adv_i  = with_adv;
        addr_i = a;
        tick();
        load_i = 1'b0;
        adv_i  = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; load_i = 1'b0; adv_i = 1'b0; order_i = 1'b0; addr_i = 16'hFFFF;
        tick();
        tick();
        // R1: reset state
        check(burst_lo_o == 2'b00, "R1", burst_lo_o, 0);
        check(addr_hi_o == '0, "R1", addr_hi_o, 0);
        rst_n = 1'b1;
        tick();
        check(burst_lo_o == 2'b00 && addr_hi_o == '0, "R1", {addr_hi_o, burst_lo_o}, 0);

        // sweep both orders and all starts: R2, R3, R5, R6, R7, R4
        for (int o = 0; o < 2; o++) begin
            for (int s = 0; s < 4; s++) begin
                logic [ADDR_W-1:0] a;
                a = 16'hA5C0 ^ 16'(s * 16'h1234) ^ 16'(o * 16'h0F00);
                a[1:0] = 2'(s);
                order_i = 1'(o);
                do_load(a, 1'b0);
                check(burst_lo_o == 2'(s), "R2", burst_lo_o, s);
                check(addr_hi_o == a[ADDR_W-1:2], "R3", addr_hi_o, a[ADDR_W-1:2]);
                for (int k = 1; k < 7; k++) begin
                    adv_i  = 1'b1;
                    addr_i = ~a;   // R3: not captured without load
                    tick();
                    check(burst_lo_o == expect_lo(1'(o), 2'(s), k),
                          (o != 0) ? "R5/R7" : "R6/R7", burst_lo_o, expect_lo(1'(o), 2'(s), k));
                    check(addr_hi_o == a[ADDR_W-1:2], "R3", addr_hi_o, a[ADDR_W-1:2]);
                end
                adv_i = 1'b0;
                tick();
                tick();
                // R4: suspend keeps the beat-6 address
                check(burst_lo_o == expect_lo(1'(o), 2'(s), 6), "R4", burst_lo_o,
                      expect_lo(1'(o), 2'(s), 6));
                adv_i = 1'b1;
                tick();
                adv_i = 1'b0;
                check(burst_lo_o == expect_lo(1'(o), 2'(s), 7), "R4/R7", burst_lo_o,
                      expect_lo(1'(o), 2'(s), 7));
            end
        end

        // R8: load together with advance restarts at new start
        order_i = 1'b1;
        do_load(16'h1237, 1'b0);
        adv_i = 1'b1;
        tick();
        tick();
        do_load(16'hBEE2, 1'b1);
        check(burst_lo_o == 2'b10, "R8", burst_lo_o, 2);
        check(addr_hi_o == 14'(16'hBEE2 >> 2), "R8", addr_hi_o, 16'hBEE2 >> 2);
        adv_i = 1'b1;
        tick();
        adv_i = 1'b0;
        check(burst_lo_o == 2'b11, "R8", burst_lo_o, 3);

        // R9: order change mid-burst remaps immediately (start 01, beat 1)
        order_i = 1'b0;
        do_load(16'h4441, 1'b0);
        adv_i = 1'b1;
        tick();
        adv_i = 1'b0;
        check(burst_lo_o == 2'b10, "R9", burst_lo_o, 2);
        order_i = 1'b1;
        #1;
        check(burst_lo_o == 2'b00, "R9", burst_lo_o, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule